// File: doc/BRIEF.md
# Arithmetic Galois-Field Substitution Unit

This block replaces two 8-bit substitution tables with arithmetic. Each incoming byte goes through a GF(2^8) multiplicative inverse and an affine bit-mixing map. For the inverse direction the order is reversed and the inverse affine map is used. Two variants are offered. The standard variant is the usual AES byte substitution. The tweaked variant XORs a fixed 8-bit constant (0xA5 by default) between the field inverse and the affine map. That gives a different permutation of the 256 byte values, and each variant has its own exact inverse.

A single field inverter is shared by both directions. A multiplexer in front of the inverter and one behind it pick the data path. By default the result is registered: a byte presented with its valid strobe appears at the output on the next clock edge, with a valid flag that follows the strobe one cycle later. A parameter selects a purely combinational build instead.

Top module: `gf_sbox_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_byte` are cleared to 0 on that edge.
- R2: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low in the cycle after an edge that sampled `in_valid` low.
- R3: Field arithmetic reduces by x^8+x^4+x^3+x+1 (0x11B), and the field inverse of 0x00 is taken as 0x00. With the standard variant forward, 0x00 maps to 0x63 and 0x53 maps to 0xED.
- R4: The forward affine map sets output bit i to the XOR of input bits i, i+4, i+5, i+6 and i+7 (indices mod 8), then XORs 0x63. Standard forward (`variant_sel`=0, `dir_inv`=0) is this map applied to the field inverse of the input, for all 256 inputs.
- R5: The inverse affine map sets output bit i to the XOR of input bits i+2, i+5 and i+7 (indices mod 8), then XORs 0x05. Standard inverse (`variant_sel`=0, `dir_inv`=1) is the field inverse of this map applied to the input, for all 256 inputs.
- R6: Tweaked forward (`variant_sel`=1, `dir_inv`=0) XORs 0xA5 into the field inverse and then applies the forward affine map. In particular, 0x00 maps to 0x6C.
- R7: Tweaked inverse (`variant_sel`=1, `dir_inv`=1) applies the inverse affine map, XORs 0xA5, and then takes the field inverse.
- R8: For both variants, the inverse direction applied to the forward result returns the original byte, for all 256 values.
- R9: The forward direction of each variant is a permutation: its 256 outputs are pairwise distinct.
- R10: A cycle with `in_valid` low leaves `out_byte` unchanged, whatever `in_byte`, `variant_sel` and `dir_inv` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Byte to substitute |
| variant_sel | input | 1 | 0 = standard permutation, 1 = tweaked permutation |
| dir_inv | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_byte | output | 8 | Substituted byte |

## Verification
All 256 bytes are driven through each of the four variant/direction combinations. Each result is compared with a model that finds the field inverse by search rather than by exponentiation. A wrong reduction polynomial, bit tap, constant or tweak position therefore shows up as a mismatch. The forward outputs are fed back through the inverse direction, and they are collected in a bitmap. The round trip catches an inverse path that does not undo its own forward path, and the bitmap catches a forward map that is not a permutation. The two named anchor values (0x00 and 0x53), back-to-back strobes and idle cycles with changing inputs separate timing faults from arithmetic faults.

// File: rtl/gfsb_pkg.sv
// Package: shared constants, direction/variant encodings and GF(2^8) helpers.
// Assumes: field elements are 8-bit polynomials over GF(2), bit 0 = x^0.
package gfsb_pkg;

    localparam int          GF_W         = 8;
    localparam logic [7:0]  GF_POLY_LOW  = 8'h1B;  // x^8 term implied
    localparam logic [7:0]  FWD_AFF_C    = 8'h63;
    localparam logic [7:0]  INV_AFF_C    = 8'h05;
    localparam logic [7:0]  TWEAK_BYTE   = 8'hA5;

    typedef enum logic { SB_FWD = 1'b0, SB_INV = 1'b1 } sb_dir_e;
    typedef enum logic { SB_STD = 1'b0, SB_TWK = 1'b1 } sb_var_e;

    // Shift-and-add product of two field elements, reduced by poly_low.
    function automatic logic [7:0] gf_mul(input logic [7:0] a,
                                          input logic [7:0] b,
                                          input logic [7:0] poly_low);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? poly_low : 8'h00);
        end
        return acc;
    endfunction

endpackage

// File: rtl/gf_inverse.sv
// Module: gf_inverse
// Computes a^254 in GF(2^8), i.e. the multiplicative inverse for a != 0.
// It gives 0 for a == 0. Built as a chain of squarings with a running
// product: a^254 = a^2 * a^4 * ... * a^128.
// Assumes: POLY_LOW is the low byte of an irreducible degree-8 polynomial.
module gf_inverse #(
    parameter logic [7:0] POLY_LOW = gfsb_pkg::GF_POLY_LOW,
    parameter int          STEPS    = 7
) (
    input  logic [7:0] a,
    output logic [7:0] y
);
    logic [7:0] pw  [0:STEPS];
    logic [7:0] acc [0:STEPS];

    assign pw[0]  = a;
    assign acc[0] = 8'h01;

    // Each stage squares the power and folds it into the running product.
    for (genvar k = 1; k <= STEPS; k++) begin : g_stage
        assign pw[k]  = gfsb_pkg::gf_mul(pw[k-1], pw[k-1], POLY_LOW);
        assign acc[k] = gfsb_pkg::gf_mul(acc[k-1], pw[k], POLY_LOW);
    end

    assign y = acc[STEPS];
endmodule

// File: rtl/sbox_affine_fwd.sv
// Module: sbox_affine_fwd
// Forward affine map: out[i] = x[i]^x[i+4]^x[i+5]^x[i+6]^x[i+7] (mod W) ^ C[i].
// Assumes: W = 8 for the standard tap set.
module sbox_affine_fwd #(
    parameter int          W = 8,
    parameter logic [7:0]  C = gfsb_pkg::FWD_AFF_C
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    // One XOR tree per output bit, taps rotated with the bit index.
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int T4 = (i + 4) % W;
        localparam int T5 = (i + 5) % W;
        localparam int T6 = (i + 6) % W;
        localparam int T7 = (i + 7) % W;
        assign y[i] = x[i] ^ x[T4] ^ x[T5] ^ x[T6] ^ x[T7] ^ C[i];
    end
endmodule

// File: rtl/sbox_affine_inv.sv
// Module: sbox_affine_inv
// Inverse affine map: out[i] = x[i+2]^x[i+5]^x[i+7] (mod W) ^ C[i].
// Assumes: W = 8, paired with sbox_affine_fwd using constant 0x63.
module sbox_affine_inv #(
    parameter int          W = 8,
    parameter logic [7:0]  C = gfsb_pkg::INV_AFF_C
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    // Three-tap XOR per output bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int T2 = (i + 2) % W;
        localparam int T5 = (i + 5) % W;
        localparam int T7 = (i + 7) % W;
        assign y[i] = x[T2] ^ x[T5] ^ x[T7] ^ C[i];
    end
endmodule

// File: rtl/gf_sbox_unit.sv
// Module: gf_sbox_unit (top)
// Arithmetic byte substitution with two variants (standard / tweaked) and
// two directions. A single field inverter is shared by both directions:
//   forward: y = Afwd(inv(x) ^ tw)
//   inverse: y = inv(Ainv(x) ^ tw)
// where tw = TWEAK when variant_sel = 1, otherwise 0.
// With OUT_REG = 1 the result and valid flag are registered (1-cycle
// latency) and the output holds when in_valid is low. With OUT_REG = 0
// the path is combinational.
// Assumes: synchronous active-low reset; inputs are stable around clk.
module gf_sbox_unit #(
    parameter logic [7:0] TWEAK   = gfsb_pkg::TWEAK_BYTE,
    parameter logic [7:0] POLY    = gfsb_pkg::GF_POLY_LOW,
    parameter bit         OUT_REG = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       variant_sel,
    input  logic       dir_inv,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    import gfsb_pkg::*;

    sb_dir_e    dir_e;
    sb_var_e    var_e;
    logic [7:0] tw;
    logic [7:0] unaff;
    logic [7:0] inv_in;
    logic [7:0] inv_out;
    logic [7:0] aff_out;
    logic [7:0] sub_res;

    assign dir_e = sb_dir_e'(dir_inv);
    assign var_e = sb_var_e'(variant_sel);

    // Tweak is present only for the second variant.
    assign tw = (var_e == SB_TWK) ? TWEAK : 8'h00;

    sbox_affine_inv #(.W(GF_W), .C(INV_AFF_C)) u_unaff (
        .x (in_byte),
        .y (unaff)
    );

    // Inverter operand: raw byte forward, un-affined and untweaked inverse.
    always_comb begin
        inv_in = (dir_e == SB_INV) ? (unaff ^ tw) : in_byte;
    end

    gf_inverse #(.POLY_LOW(POLY)) u_inv (
        .a (inv_in),
        .y (inv_out)
    );

    sbox_affine_fwd #(.W(GF_W), .C(FWD_AFF_C)) u_aff (
        .x (inv_out ^ tw),
        .y (aff_out)
    );

    // Result select: affine output forward, inverter output inverse.
    always_comb begin
        sub_res = (dir_e == SB_INV) ? inv_out : aff_out;
    end

    if (OUT_REG) begin : g_reg
        // Capture result on strobe; valid follows the strobe by one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_byte  <= 8'h00;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_byte <= sub_res;
            end
        end

        // R2
        valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R2
        valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R10
        hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_byte));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_byte  = sub_res;
    end

    // R3
    inv_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_in != 8'h00) |-> (gf_mul(inv_in, inv_out, POLY) == 8'h01));
    // R3
    inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_in == 8'h00) |-> (inv_out == 8'h00));
endmodule

// File: tb/gf_sbox_unit_test.sv
module gf_sbox_unit_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       variant_sel = 1'b0;
    logic       dir_inv = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;

    gf_sbox_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .variant_sel(variant_sel), .dir_inv(dir_inv),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---- independent reference model ----
    function automatic logic [7:0] ref_prod(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int j = 15; j >= 8; j--) if (p[j]) p = p ^ (16'h011B << (j - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] ref_recip(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        for (int c = 1; c < 256; c++) if (ref_prod(a, 8'(c)) == 8'h01) r = 8'(c);
        return r;
    endfunction

    function automatic logic [7:0] ref_aff(input logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++)
            o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
        return o ^ 8'h63;
    endfunction

    function automatic logic [7:0] ref_unaff(input logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++)
            o[i] = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8];
        return o ^ 8'h05;
    endfunction

    function automatic logic [7:0] ref_sub(input logic [7:0] x, input logic v, input logic d);
        logic [7:0] t;
        t = v ? 8'hA5 : 8'h00;
        return d ? ref_recip(ref_unaff(x) ^ t) : ref_aff(ref_recip(x) ^ t);
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one byte with strobe, return result sampled on the next negedge.
    task automatic apply(input logic [7:0] x, input logic v, input logic d,
                         output logic [7:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_byte = x; variant_sel = v; dir_inv = d;
        @(negedge clk);
        in_valid = 1'b0;
        res = out_byte;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; in_byte = 8'h53;
        repeat (3) @(negedge clk);
        check8("R1 valid", {7'b0, out_valid}, 8'h00);
        check8("R1 byte", out_byte, 8'h00);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_anchors();
        logic [7:0] r;
        apply(8'h00, 1'b0, 1'b0, r); check8("R3 std fwd 00", r, 8'h63);
        apply(8'h53, 1'b0, 1'b0, r); check8("R3 std fwd 53", r, 8'hED);
        apply(8'h00, 1'b1, 1'b0, r); check8("R6 twk fwd 00", r, 8'h6C);
        apply(8'h63, 1'b0, 1'b1, r); check8("R5 std inv 63", r, 8'h00);
    endtask

    task automatic t_exhaustive(input logic v, input logic d, input string req);
        logic [7:0] r;
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), v, d, r);
            check8(req, r, ref_sub(8'(x), v, d));
        end
    endtask

    // R8 round trip and R9 permutation for one variant.
    task automatic t_roundtrip(input logic v);
        logic [7:0] f;
        logic [7:0] b;
        logic [255:0] seen;
        seen = '0;
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), v, 1'b0, f);
            apply(f, v, 1'b1, b);
            check8("R8 round trip", b, 8'(x));
            check8("R9 distinct", {7'b0, seen[f]}, 8'h00);
            seen[f] = 1'b1;
        end
    endtask

    task automatic t_stream_and_hold();
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h3C; variant_sel = 1'b1; dir_inv = 1'b0;
        @(negedge clk);
        check8("R2 valid b2b 1", {7'b0, out_valid}, 8'h01);
        check8("R7 b2b 1", out_byte, ref_sub(8'h3C, 1'b1, 1'b0));
        in_byte = 8'h9A; dir_inv = 1'b1;
        @(negedge clk);
        check8("R7 b2b 2", out_byte, ref_sub(8'h9A, 1'b1, 1'b1));
        in_valid = 1'b0; in_byte = 8'h11; variant_sel = 1'b0; dir_inv = 1'b0;
        @(negedge clk);
        check8("R2 valid idle", {7'b0, out_valid}, 8'h00);
        check8("R10 hold 1", out_byte, ref_sub(8'h9A, 1'b1, 1'b1));
        in_byte = 8'hFF; dir_inv = 1'b1;
        @(negedge clk);
        check8("R10 hold 2", out_byte, ref_sub(8'h9A, 1'b1, 1'b1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_anchors();
        t_exhaustive(1'b0, 1'b0, "R4 std fwd");
        t_exhaustive(1'b0, 1'b1, "R5 std inv");
        t_exhaustive(1'b1, 1'b0, "R6 twk fwd");
        t_exhaustive(1'b1, 1'b1, "R7 twk inv");
        t_roundtrip(1'b0);
        t_roundtrip(1'b1);
        t_stream_and_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule